// File: doc/BRIEF.md
# SDRAM Command Timing Auditor

This block sits passively on the command and address lines of a four-bank single-data-rate SDRAM. It never drives the memory. On every rising clock edge it turns the chip-select, row-strobe, column-strobe and write-enable lines into a command. It updates a model of each bank: whether the bank is open, and how many clocks have passed since that bank was last activated and last precharged. It then tests the command against a set of minimum spacings measured in clocks and against the bank states.

Each broken rule sets its own bit in a violation bitmap. A bit stays set until reset. The block also keeps a free-running cycle count, and it captures that count for the first cycle in which any rule broke. All spacing limits are parameters, so one build can audit any speed grade. The defaults match a 100 MHz part. A simple interval counter also reports when refreshes stop arriving.

Top module: `sdram_cmd_auditor`

## Requirements
- R1: With cs_n low, {ras_n,cas_n,we_n} decodes as follows: 000 mode-register set, 011 activate, 101 read, 100 write, 010 precharge, 001 auto-refresh, 111 no-operation. Any other code (for example 110) changes no bank state but still counts as a command for R6. cs_n high is a deselect and counts as no command.
- R2: A read or write to an open bank fewer than T_RCD (default 2) clocks after that bank's activate sets viol[0].
- R3: A precharge that closes an open bank fewer than T_RAS (default 5) clocks after its activate sets viol[1].
- R4: An activate fewer than T_RP (default 2) clocks after a precharge that targeted the same bank sets viol[2].
- R5: Two activates to the same bank fewer than T_RC (default 7) clocks apart set viol[3].
- R6: Any command other than no-operation or deselect fewer than T_MRD (default 2) clocks after a mode-register set sets viol[4].
- R7: An auto-refresh while any bank is open, or without cke high in both the previous and the current cycle, sets viol[5]. The previous-cycle cke reads as low in the first cycle after reset.
- R8: A read or write to a closed bank, or an activate to an open bank, sets viol[6].
- R9: When REF_INTERVAL (default 1562) consecutive cycles pass without an auto-refresh, counted from reset or from the last refresh, viol[7] sets in the last of those cycles.
- R10: A precharge with a10 high closes all banks and restarts the T_RP window of every bank. With a10 low it acts on the bank given by ba only.
- R11: Reset clears viol and first_valid. Violation bits are sticky. The cycle count is 0 in the first clock after reset. The first cycle that sets any bit is latched into first_cycle, first_valid rises, and both then hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; all lines sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock-enable line of the memory |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | $clog2(BANKS) | Bank address |
| a10 | input | 1 | Address bit 10; selects all banks for precharge |
| viol | output | 8 | Sticky per-rule violation bitmap, bit numbers as in R2 to R9 |
| first_valid | output | 1 | High once any violation has been recorded |
| first_cycle | output | CYC_W | Cycle count of the first violating cycle |

## Verification
Several rules can fire on one command. An activate placed one clock after a precharge, and less than T_RC after the bank's earlier activate, breaks both the precharge-recovery rule and the row-cycle rule. A command right after a mode-register set can also break a bank rule at the same time. The bench builds these cases on purpose and also reaches them through random command streams. It requires every affected bit to appear in the same cycle, with first_cycle pointing at that one cycle.

// File: rtl/sdram_audit_pkg.sv
package sdram_audit_pkg;
  typedef enum logic [3:0] {
    CMD_DESEL, CMD_NOP, CMD_MRS, CMD_ACT, CMD_RD,
    CMD_WR, CMD_PRE, CMD_REF, CMD_OTHER
  } cmd_e;

  localparam int NRULE = 8;
  localparam int V_RCD = 0;
  localparam int V_RAS = 1;
  localparam int V_RP  = 2;
  localparam int V_RC  = 3;
  localparam int V_MRD = 4;
  localparam int V_REF = 5;
  localparam int V_ST  = 6;
  localparam int V_RIV = 7;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_audit_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b000:  cmd = CMD_MRS;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b111:  cmd = CMD_NOP;
        default: cmd = CMD_OTHER;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_audit_pkg::*;
#(
  parameter int CW    = 3,
  parameter int T_RCD = 2,
  parameter int T_RAS = 5,
  parameter int T_RP  = 2,
  parameter int T_RC  = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  cmd_e cmd,
  input  logic sel,
  input  logic a10,
  output logic active,
  output logic st_err,
  output logic rcd_err,
  output logic ras_err,
  output logic rp_err,
  output logic rc_err
);
  localparam logic [CW-1:0] L_RCD = CW'(T_RCD);
  localparam logic [CW-1:0] L_RAS = CW'(T_RAS);
  localparam logic [CW-1:0] L_RP  = CW'(T_RP);
  localparam logic [CW-1:0] L_RC  = CW'(T_RC);
  localparam logic [CW-1:0] SAT   = '1;

  logic [CW-1:0] since_act, since_pre;
  logic is_act, is_rw, is_pre;

  assign is_act = (cmd == CMD_ACT) && sel;
  assign is_rw  = ((cmd == CMD_RD) || (cmd == CMD_WR)) && sel;
  assign is_pre = (cmd == CMD_PRE) && (a10 || sel);

  assign st_err  = (is_rw && !active) || (is_act && active);
  assign rcd_err = is_rw && active && (since_act < L_RCD);
  assign ras_err = is_pre && active && (since_act < L_RAS);
  assign rp_err  = is_act && (since_pre < L_RP);
  assign rc_err  = is_act && (since_act < L_RC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      since_act <= SAT;
      since_pre <= SAT;
    end else begin
      if (is_act) begin
        active    <= 1'b1;
        since_act <= CW'(1);
      end else if (since_act != SAT) begin
        since_act <= since_act + CW'(1);
      end
      if (is_pre) begin
        active    <= 1'b0;
        since_pre <= CW'(1);
      end else if (since_pre != SAT) begin
        since_pre <= since_pre + CW'(1);
      end
    end
  end
endmodule

// File: rtl/sdram_refresh_watch.sv
module sdram_refresh_watch #(
  parameter int REF_INTERVAL = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic is_ref,
  output logic overdue
);
  localparam int RW = $clog2(REF_INTERVAL + 1);
  localparam logic [RW-1:0] LAST = RW'(REF_INTERVAL - 1);

  logic [RW-1:0] gap;

  assign overdue = !is_ref && (gap == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)        gap <= '0;
    else if (is_ref)   gap <= '0;
    else if (gap != LAST) gap <= gap + RW'(1);
  end
endmodule

// File: rtl/sdram_cmd_auditor.sv
module sdram_cmd_auditor
  import sdram_audit_pkg::*;
#(
  parameter int BANKS        = 4,
  parameter int T_RCD        = 2,
  parameter int T_RAS        = 5,
  parameter int T_RP         = 2,
  parameter int T_RC         = 7,
  parameter int T_MRD        = 2,
  parameter int REF_INTERVAL = 1562,
  parameter int CYC_W        = 32,
  localparam int BA_W        = $clog2(BANKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [BA_W-1:0]  ba,
  input  logic             a10,
  output logic [NRULE-1:0] viol,
  output logic             first_valid,
  output logic [CYC_W-1:0] first_cycle
);
  localparam int LIM_A = (T_RC > T_RAS) ? T_RC : T_RAS;
  localparam int LIM_B = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int LIM_C = (LIM_A > LIM_B) ? LIM_A : LIM_B;
  localparam int LIM   = (LIM_C > T_MRD) ? LIM_C : T_MRD;
  localparam int CW    = $clog2(LIM + 1);
  localparam logic [CW-1:0] SAT   = '1;
  localparam logic [CW-1:0] L_MRD = CW'(T_MRD);

  cmd_e cmd;
  logic [BANKS-1:0] b_act, b_st, b_rcd, b_ras, b_rp, b_rc;
  logic [CW-1:0]    since_mrs;
  logic             cke_q, ref_late;
  logic [CYC_W-1:0] cyc;
  logic [NRULE-1:0] hits;

  sdram_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  for (genvar i = 0; i < BANKS; i++) begin : g_bank
    sdram_bank_track #(
      .CW(CW), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RC(T_RC)
    ) u_bank (
      .clk(clk), .rst_n(rst_n), .cmd(cmd),
      .sel(ba == BA_W'(i)), .a10(a10),
      .active(b_act[i]), .st_err(b_st[i]), .rcd_err(b_rcd[i]),
      .ras_err(b_ras[i]), .rp_err(b_rp[i]), .rc_err(b_rc[i])
    );
  end

  sdram_refresh_watch #(.REF_INTERVAL(REF_INTERVAL)) u_refw (
    .clk(clk), .rst_n(rst_n), .is_ref(cmd == CMD_REF), .overdue(ref_late)
  );

  always_comb begin
    hits        = '0;
    hits[V_RCD] = |b_rcd;
    hits[V_RAS] = |b_ras;
    hits[V_RP]  = |b_rp;
    hits[V_RC]  = |b_rc;
    hits[V_ST]  = |b_st;
    hits[V_MRD] = (cmd != CMD_NOP) && (cmd != CMD_DESEL) && (since_mrs < L_MRD);
    hits[V_REF] = (cmd == CMD_REF) && ((|b_act) || !(cke_q && cke));
    hits[V_RIV] = ref_late;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_mrs   <= SAT;
      cke_q       <= 1'b0;
      cyc         <= '0;
      viol        <= '0;
      first_valid <= 1'b0;
      first_cycle <= '0;
    end else begin
      cke_q <= cke;
      cyc   <= cyc + CYC_W'(1);
      if (cmd == CMD_MRS)     since_mrs <= CW'(1);
      else if (since_mrs != SAT) since_mrs <= since_mrs + CW'(1);
      viol <= viol | hits;
      if (!first_valid && (hits != '0)) begin
        first_valid <= 1'b1;
        first_cycle <= cyc;
      end
    end
  end
endmodule

// File: rtl/sdram_audit_checks.sv
module sdram_audit_checks
  import sdram_audit_pkg::*;
#(
  parameter int BANKS        = 4,
  parameter int T_RCD        = 2,
  parameter int T_RAS        = 5,
  parameter int T_RP         = 2,
  parameter int T_RC         = 7,
  parameter int T_MRD        = 2,
  parameter int REF_INTERVAL = 1562,
  parameter int CYC_W        = 32,
  localparam int BA_W        = $clog2(BANKS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cke,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [BA_W-1:0]  ba,
  input logic             a10,
  input logic [NRULE-1:0] viol,
  input logic             first_valid,
  input logic [CYC_W-1:0] first_cycle
);
  logic armed;
  logic rw_now, act_now, mrs_now, pre_now, ref_now, live_now;

  assign act_now  = !cs_n && !ras_n && cas_n && we_n;
  assign rw_now   = !cs_n && ras_n && !cas_n;
  assign mrs_now  = !cs_n && !ras_n && !cas_n && !we_n;
  assign pre_now  = !cs_n && !ras_n && cas_n && !we_n;
  assign ref_now  = !cs_n && !ras_n && !cas_n && we_n;
  assign live_now = !cs_n && !(ras_n && cas_n && we_n);

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((viol & $past(viol)) == $past(viol))); // R11
  AST_FIRST_MATCHES_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    first_valid == (viol != '0)); // R11
  AST_FIRST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(first_valid)) |-> $stable(first_cycle)); // R11
  AST_RCD_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (T_RCD > 1) && rw_now && $past(act_now) && ($past(ba) == ba))
      |=> viol[V_RCD]); // R2
  AST_MRD_NEXT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (T_MRD > 1) && live_now && $past(mrs_now)) |=> viol[V_MRD]); // R6
  AST_REF_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_now && !cke) |=> viol[V_REF]); // R7
  AST_ACCESS_AFTER_PREALL: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && rw_now && $past(pre_now && a10)) |=> viol[V_ST]); // R10
endmodule

bind sdram_cmd_auditor sdram_audit_checks #(
  .BANKS(BANKS), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RC(T_RC),
  .T_MRD(T_MRD), .REF_INTERVAL(REF_INTERVAL), .CYC_W(CYC_W)
) u_chk (.*);

// File: tb/tb_sdram_cmd_auditor.sv
`timescale 1ns/1ps
module tb_sdram_cmd_auditor;
  localparam int T_RCD = 2, T_RAS = 5, T_RP = 2, T_RC = 7, T_MRD = 2;
  localparam int REF_INT = 1562;
  localparam logic [2:0] C_MRS = 3'b000, C_ACT = 3'b011, C_RD = 3'b101,
    C_WR = 3'b100, C_PRE = 3'b010, C_REF = 3'b001, C_NOP = 3'b111, C_OTH = 3'b110;

  logic clk = 0, rst_n = 0, cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, a10 = 0;
  logic [1:0] ba = 0;
  logic [7:0] viol;
  logic first_valid;
  logic [31:0] first_cycle;

  int checks = 0, failures = 0;

  sdram_cmd_auditor dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .viol(viol),
    .first_valid(first_valid), .first_cycle(first_cycle)
  );

  always #2 clk = ~clk;

  // reference model state, time-stamped
  int t;
  bit m_act[4];
  int m_lact[4], m_lpre[4], m_lmrs, m_lref;
  bit m_ckep, m_fv;
  int m_fc;
  logic [7:0] m_viol;

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h (t=%0d)", tag, what, act, exp, t);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; cs_n = 1; cke = 1; ras_n = 1; cas_n = 1; we_n = 1;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    t = 0; m_lmrs = -100000; m_lref = -1; m_ckep = 0; m_fv = 0; m_fc = 0; m_viol = '0;
    for (int i = 0; i < 4; i++) begin
      m_act[i] = 0; m_lact[i] = -100000; m_lpre[i] = -100000;
    end
  endtask

  task automatic step(input string tag, input bit cs, input logic [2:0] rcw,
                      input logic [1:0] b, input bit ad, input bit ck);
    logic [7:0] h;
    bit live, any;
    cs_n = cs; {ras_n, cas_n, we_n} = rcw; ba = b; a10 = ad; cke = ck;
    h = '0; any = 0;
    for (int i = 0; i < 4; i++) any |= m_act[i];
    live = !cs && (rcw != C_NOP);
    if (live && (t - m_lmrs < T_MRD)) h[4] = 1;
    if (!cs) begin
      case (rcw)
        C_RD, C_WR: if (!m_act[b]) h[6] = 1; else if (t - m_lact[b] < T_RCD) h[0] = 1;
        C_ACT: begin
          if (m_act[b]) h[6] = 1;
          if (t - m_lpre[b] < T_RP) h[2] = 1;
          if (t - m_lact[b] < T_RC) h[3] = 1;
        end
        C_PRE: for (int i = 0; i < 4; i++)
          if ((ad || i == b) && m_act[i] && (t - m_lact[i] < T_RAS)) h[1] = 1;
        C_REF: if (any || !(m_ckep && ck)) h[5] = 1;
        default: ;
      endcase
    end
    if (!(!cs && rcw == C_REF) && (t - m_lref >= REF_INT)) h[7] = 1;
    @(posedge clk);
    #1;
    if (!cs) begin
      case (rcw)
        C_ACT: begin m_act[b] = 1; m_lact[b] = t; end
        C_PRE: for (int i = 0; i < 4; i++) if (ad || i == b) begin m_act[i] = 0; m_lpre[i] = t; end
        C_MRS: m_lmrs = t;
        C_REF: m_lref = t;
        default: ;
      endcase
    end
    m_ckep = ck;
    if (h != 0 && !m_fv) begin m_fv = 1; m_fc = t; end
    m_viol |= h;
    check(tag, "viol", viol, m_viol);
    check(tag, "first_valid", first_valid, m_fv);
    if (m_fv) check(tag, "first_cycle", first_cycle, m_fc);
    t++;
  endtask

  task automatic cmd(input string tag, input logic [2:0] rcw, input logic [1:0] b, input bit ad);
    step(tag, 1'b0, rcw, b, ad, 1'b1);
  endtask

  task automatic nops(input string tag, input int n);
    for (int i = 0; i < n; i++) cmd(tag, C_NOP, 2'd0, 1'b0);
  endtask

  task automatic expect_out(input string tag, input logic [7:0] ev, input bit efv, input int efc);
    check(tag, "viol(direct)", viol, ev);
    check(tag, "first_valid(direct)", first_valid, efv);
    if (efv) check(tag, "first_cycle(direct)", first_cycle, efc);
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0417));
    // R11: reset state
    do_reset();
    #1 expect_out("R11", 8'h00, 0, 0);

    // R2 legal spacing, then too close
    do_reset();
    cmd("R2", C_ACT, 2'd0, 0); nops("R2", 1); cmd("R2", C_RD, 2'd0, 0);
    expect_out("R2", 8'h00, 0, 0);
    do_reset();
    cmd("R2", C_ACT, 2'd1, 0); cmd("R2", C_WR, 2'd1, 0);
    expect_out("R2", 8'h01, 1, 1);

    // R3 precharge too soon after activate
    do_reset();
    cmd("R3", C_ACT, 2'd2, 0); nops("R3", 2); cmd("R3", C_PRE, 2'd2, 0);
    expect_out("R3", 8'h02, 1, 3);

    // R4 + R5 coinciding on one activate
    do_reset();
    cmd("R5", C_ACT, 2'd0, 0); nops("R5", 4); cmd("R4", C_PRE, 2'd0, 0);
    cmd("R4", C_ACT, 2'd0, 0);
    expect_out("R4", 8'h0C, 1, 6);

    // R6 mode-register window; R1 other code counts as a command
    do_reset();
    cmd("R6", C_MRS, 2'd0, 0); cmd("R6", C_ACT, 2'd3, 0);
    expect_out("R6", 8'h10, 1, 1);
    do_reset();
    cmd("R6", C_MRS, 2'd0, 0); nops("R6", 1); cmd("R6", C_ACT, 2'd3, 0);
    step("R1", 1'b1, C_MRS, 2'd0, 0, 1); step("R1", 1'b1, C_ACT, 2'd1, 0, 1);
    expect_out("R1", 8'h00, 0, 0);
    do_reset();
    cmd("R1", C_MRS, 2'd0, 0); cmd("R1", C_OTH, 2'd0, 0);
    expect_out("R1", 8'h10, 1, 1);

    // R7 refresh rules
    do_reset();
    cmd("R7", C_ACT, 2'd2, 0); nops("R7", 2); cmd("R7", C_REF, 2'd0, 0);
    expect_out("R7", 8'h20, 1, 3);
    do_reset();
    step("R7", 1'b0, C_NOP, 2'd0, 0, 1'b0); cmd("R7", C_REF, 2'd0, 0);
    expect_out("R7", 8'h20, 1, 1);
    do_reset();
    nops("R7", 1); cmd("R7", C_REF, 2'd0, 0);
    expect_out("R7", 8'h00, 0, 0);

    // R8 state errors
    do_reset();
    cmd("R8", C_RD, 2'd0, 0);
    expect_out("R8", 8'h40, 1, 0);
    do_reset();
    cmd("R8", C_ACT, 2'd1, 0); nops("R8", 8); cmd("R8", C_ACT, 2'd1, 0);
    expect_out("R8", 8'h40, 1, 9);

    // R10 precharge scope
    do_reset();
    cmd("R10", C_ACT, 2'd0, 0); cmd("R10", C_ACT, 2'd3, 0); nops("R10", 5);
    cmd("R10", C_PRE, 2'd1, 1); nops("R10", 1); cmd("R10", C_RD, 2'd3, 0);
    expect_out("R10", 8'h40, 1, 9);
    do_reset();
    cmd("R10", C_ACT, 2'd0, 0); cmd("R10", C_ACT, 2'd1, 0); nops("R10", 5);
    cmd("R10", C_PRE, 2'd0, 0); cmd("R10", C_RD, 2'd1, 0); nops("R10", 1);
    cmd("R10", C_ACT, 2'd0, 0);
    expect_out("R10", 8'h00, 0, 0);

    // R9 refresh interval
    do_reset();
    nops("R9", REF_INT - 1);
    expect_out("R9", 8'h00, 0, 0);
    nops("R9", 1);
    expect_out("R9", 8'h80, 1, REF_INT - 1);
    do_reset();
    nops("R9", 600); cmd("R9", C_REF, 2'd0, 0); nops("R9", REF_INT - 1);
    expect_out("R9", 8'h00, 0, 0);

    // random streams against the model
    for (int ep = 0; ep < 60; ep++) begin
      do_reset();
      for (int k = 0; k < 30; k++) begin
        int r;
        logic [2:0] op;
        bit cs;
        r = $urandom_range(99);
        cs = 0;
        if (r < 30) op = C_NOP;
        else if (r < 50) op = C_ACT;
        else if (r < 60) op = C_RD;
        else if (r < 70) op = C_WR;
        else if (r < 85) op = C_PRE;
        else if (r < 90) op = C_REF;
        else if (r < 93) op = C_MRS;
        else if (r < 95) op = C_OTH;
        else begin op = 3'($urandom_range(7)); cs = 1; end
        step("R1", cs, op, 2'($urandom_range(3)), 1'($urandom_range(1)),
             ($urandom_range(9) != 0));
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule